// File: doc/BRIEF.md
# Bit-Banged Display Link GPIO Port

This block is a 32-bit register that lets software run a two-wire serial link to a monitor (the display data channel, built on I2C) by toggling pins. Each write gives an output value and an output enable for the clock line (SCL) and the data line (SDA). The block drives two open-drain pads. It returns the pad levels it senses in readback bits of the same register, so software can read the line state back on the next access.

A parameter `BASE` moves the whole bit group by one position. A second parameter, `LANE_GATED`, picks one of two variants. In the full-word variant, every write replaces the register and updates the pads. In the lane-gated variant, software writes the register one byte at a time, and only the addressed byte lanes are merged into it. In this variant the pads update only when a gate bit is set and the write touched the right byte lane, so a series of partial writes cannot send glitches onto the bus. External pad levels pass through a two-flop synchronizer before they are sampled into the readback bits.

Top module: `ddc_gpio_port`

## Requirements
- R1: After reset, `rd_data` is 0, neither pad is pulled low, and the synchronizers hold the idle-high level.
- R2: With base position b: bit b is the SDA output value and bit b+1 is the SCL output value. Bit b+16 enables SDA and bit b+17 enables SCL. On an applied write, a pad is pulled low exactly when its enable is 1 and its value is 0.
- R3: A line whose enable bit is 0 is released and is never pulled low, whatever its value bit holds.
- R4: On an applied write, bits [11:8] are first cleared. Then bit b+8 is set if SDA senses high and bit b+9 is set if SCL senses high. The sensed level is the wired-AND of the block's own new drive and the synchronized external level.
- R5: Bits [11:8] cannot be written by software. They change only on an applied write.
- R6: Each external pad input passes through two flops. A level change seen at the same clock edge as a write does not reach that write's readback.
- R7: With `LANE_GATED`=1, a write changes only the byte lanes whose `wr_be` bit is 1.
- R8: With `LANE_GATED`=1, no write changes the pads while bit 25 (the gate) of the merged word is 0.
- R9: With `LANE_GATED`=1 and the gate set, a write is applied if it covers lane 2, or if it covers lane 0 while either enable bit of the merged word is 1. A write to lanes 1 or 3 alone is not applied.
- R10: With `LANE_GATED`=0, every write replaces the whole word (`wr_be` is ignored) and is applied.
- R11: Without an applied write, the pad drives stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte-lane enables (lane-gated variant only) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Stored register word with readback bits |
| scl_in | input | 1 | External SCL level (1 = high) |
| sda_in | input | 1 | External SDA level (1 = high) |
| scl_pull_low | output | 1 | Pull the SCL pad low |
| sda_pull_low | output | 1 | Pull the SDA pad low |

## Verification
The assertions assume that `wr_be` and `wr_data` are valid in every cycle where `wr_en` is high, and that the external levels are simply whatever the bus shows, with no timing relation to writes. The bench drives all inputs on the falling clock edge. It holds an external level for at least three cycles before any write whose readback it predicts, except in the one case that checks the synchronizer delay on purpose. Both variants are instantiated. Each write strobe is asserted alone, so every expected value comes from a single known write.

// File: rtl/ddc_gpio_port.sv
module ddc_gpio_port #(
  parameter int BASE       = 1,
  parameter bit LANE_GATED = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_pull_low,
  output logic        sda_pull_low
);
  localparam int SDA_O = BASE;
  localparam int SCL_O = BASE + 1;
  localparam int SDA_R = BASE + 8;
  localparam int SCL_R = BASE + 9;
  localparam int SDA_E = BASE + 16;
  localparam int SCL_E = BASE + 17;
  localparam int GATE  = 25;

  logic [31:0] q, merged, nxt;
  logic [1:0]  sda_s, scl_s;
  logic        apply, sda_lvl, scl_lvl;

  always_comb begin
    for (int i = 0; i < 4; i++)
      merged[8*i +: 8] = (!LANE_GATED || wr_be[i]) ? wr_data[8*i +: 8] : q[8*i +: 8];
  end

  assign sda_lvl = !merged[SDA_E] || merged[SDA_O];
  assign scl_lvl = !merged[SCL_E] || merged[SCL_O];

  assign apply = wr_en && (!LANE_GATED ||
                 (merged[GATE] && (wr_be[2] || (wr_be[0] && (merged[SDA_E] || merged[SCL_E])))));

  always_comb begin
    nxt        = merged;
    nxt[11:8]  = 4'b0;
    nxt[SDA_R] = sda_lvl && sda_s[1];
    nxt[SCL_R] = scl_lvl && scl_s[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q            <= '0;
      sda_s        <= 2'b11;
      scl_s        <= 2'b11;
      sda_pull_low <= 1'b0;
      scl_pull_low <= 1'b0;
    end else begin
      sda_s <= {sda_s[0], sda_in};
      scl_s <= {scl_s[0], scl_in};
      if (apply) begin
        q            <= nxt;
        sda_pull_low <= !sda_lvl;
        scl_pull_low <= !scl_lvl;
      end else if (wr_en) begin
        q <= {merged[31:12], q[11:8], merged[7:0]};
      end
    end
  end

  assign rd_data = q;

  // R5
  rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(q[11:8]));
  // R11
  pads_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable({scl_pull_low, sda_pull_low}));
  // R3
  sda_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !merged[SDA_E]) |=> !sda_pull_low);
  // R3
  scl_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !merged[SCL_E]) |=> !scl_pull_low);
  // R4
  sda_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q[SDA_R] |-> !sda_pull_low);
  // R4
  scl_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q[SCL_R] |-> !scl_pull_low);
  // R8
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LANE_GATED && wr_en && wr_be[3] && !wr_data[GATE]) |=> $stable({scl_pull_low, sda_pull_low}));
endmodule

// File: tb/ddc_gpio_port_bench.sv
module ddc_gpio_port_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wen_m = 0, wen_d = 0;
  logic [3:0] be = 0;
  logic [31:0] wd = 0;
  logic scl_in = 1, sda_in = 1;
  logic [31:0] rd_m, rd_d;
  logic scl_m, sda_m, scl_d, sda_d;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddc_gpio_port u_ddc_gpio_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wen_m), .wr_be(be), .wr_data(wd), .rd_data(rd_m),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull_low(scl_m), .sda_pull_low(sda_m));

  ddc_gpio_port #(.BASE(0), .LANE_GATED(1'b0)) u_ddc_gpio_port_dvi (
    .clk(clk), .rst_n(rst_n), .wr_en(wen_d), .wr_be(be), .wr_data(wd), .rd_data(rd_d),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull_low(scl_d), .sda_pull_low(sda_d));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; sda_in = 1; scl_in = 1;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr_m(logic [3:0] b, logic [31:0] d);
    be = b; wd = d; wen_m = 1;
    @(negedge clk); wen_m = 0;
  endtask

  task automatic wr_d(logic [3:0] b, logic [31:0] d);
    be = b; wd = d; wen_d = 1;
    @(negedge clk); wen_d = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rd", rd_m, 0);
    check("R1 pads", {scl_m, sda_m, scl_d, sda_d}, 0);
  endtask

  task automatic t_lanes();
    do_reset();
    wr_m(4'b1000, 32'hA500_0000);
    check("R7 lane3", rd_m, 32'hA500_0000);
    wr_m(4'b0001, 32'h0000_00F0);
    check("R7 lane0", rd_m, 32'hA500_00F0);
    wr_m(4'b0010, 32'h0000_FF00);
    check("R5 rb not writable", rd_m, 32'hA500_F0F0);
    check("R8 pads idle", {scl_m, sda_m}, 0);
  endtask

  task automatic t_gate_closed();
    do_reset();
    wr_m(4'b1111, 32'h0006_0000);
    check("R8 gate clear pads", {scl_m, sda_m}, 0);
    check("R8 gate clear rd", rd_m, 32'h0006_0000);
  endtask

  task automatic t_applied();
    do_reset();
    wr_m(4'b1111, 32'h0206_0000);
    check("R2 both low", {scl_m, sda_m}, 2'b11);
    check("R4 rb both low", rd_m, 32'h0206_0000);
    wr_m(4'b0001, 32'h0000_0002);
    check("R9 lane0 with enables", {scl_m, sda_m}, 2'b10);
    check("R4 sda high rb", rd_m, 32'h0206_0202);
    wr_m(4'b0010, 32'h0);
    check("R9 lane1 not applied", {scl_m, sda_m}, 2'b10);
    check("R9 lane1 rd", rd_m, 32'h0206_0202);
    wr_m(4'b0001, 32'h0000_0004);
    check("R2 scl high sda low", {scl_m, sda_m}, 2'b01);
    check("R4 scl high rb", rd_m, 32'h0206_0404);
  endtask

  task automatic t_lane0_no_en();
    do_reset();
    wr_m(4'b1111, 32'h0200_0000);
    check("R3 released rb", rd_m, 32'h0200_0600);
    sda_in = 0;
    repeat (3) @(negedge clk);
    wr_m(4'b0001, 32'h0);
    check("R9 lane0 no enables", rd_m, 32'h0200_0600);
    sda_in = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_release();
    do_reset();
    wr_m(4'b1111, 32'h0204_0000);
    check("R3 sda released", {scl_m, sda_m}, 2'b10);
    check("R3 rd", rd_m, 32'h0204_0200);
  endtask

  task automatic t_sync();
    do_reset();
    wr_m(4'b1111, 32'h0200_0000);
    sda_in = 0;
    wr_m(4'b0100, 32'h0000_0000);
    check("R6 sync delay", rd_m, 32'h0200_0600);
    repeat (3) @(negedge clk);
    wr_m(4'b0100, 32'h0000_0000);
    check("R4 wired-AND ext low", rd_m, 32'h0200_0400);
    sda_in = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_full_word();
    do_reset();
    wr_d(4'b0001, 32'h0003_0F01);
    check("R10 full word rd", rd_d, 32'h0003_0101);
    check("R10 pads", {scl_d, sda_d}, 2'b10);
    repeat (5) @(negedge clk);
    check("R11 pads hold", {scl_d, sda_d}, 2'b10);
    check("R11 rd hold", rd_d, 32'h0003_0101);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_lanes();
    t_gate_closed();
    t_applied();
    t_lane0_no_en();
    t_release();
    t_sync();
    t_full_word();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule